// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit keeps the interrupt state of a storage-card host controller. Event pulses arrive from the command sequencer, from the DMA engine and from an already debounced card-detect path. The unit latches them into a raw status word. A mask register selects which raw bits may reach the single level-sensitive interrupt line, and a master enable bit in the global control word gates that line as a whole.

Software reaches the unit over a 32-bit, word-only register port. Reads are combinational. A write takes effect at the next rising clock edge. The raw status can be cleared through two addresses: the raw view and the masked view. Card insertion and removal each set their own flag and clear the other. They also update a card-present bit in a separate status word. A DMA status word collects receive and transmit completion and keeps a summary bit.

Register map (byte offsets): 0x00 global control, 0x04 interrupt mask, 0x08 masked status, 0x0C raw status, 0x10 card status, 0x14 DMA status.

Top module: `irq_status_unit`

## Requirements
- R1: `irq` is high exactly when global control bit 4 is 1 and the bitwise AND of raw status and mask is non-zero. It follows the registers combinationally.
- R2: A read of 0x08 returns raw status AND mask, and a read of 0x0C returns raw status.
- R3: Writing to 0x08 or to 0x0C clears every raw status bit whose write-data bit is 1. Bits written 0 are kept.
- R4: A lone `card_insert` pulse sets raw bit 30, clears raw bit 31 and sets card status bit 8. A lone `card_remove` pulse sets raw bit 31, clears raw bit 30 and clears card status bit 8. When both pulses are high in the same cycle, both are ignored.
- R5: A write to 0x00 stores the data with bits 2, 1 and 0 forced to 0, so those bits always read back as 0.
- R6: In the DMA status word at 0x14, a `dma_set` pulse sets the matching bits 9..0. A pulse on bit 0 (transmit) or bit 1 (receive) also sets bit 8 (summary). A write clears the bits 9..0 that are written 1. Bits 31..10 always read 0.
- R7: After reset, global control reads 0x300, card status reads 0x100, and mask, raw status and DMA status read 0.
- R8: If an event sets a raw or DMA status bit in the same cycle that software clears it, the bit ends up set.
- R9: Addresses other than the six listed read as 0, and writes to them change no register. Writes to 0x10 and 0x08 never change the mask or the card status.
- R10: Raw bits 29..0 are set by `src_set`, and the mask register at 0x04 is fully readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_set | input | 30 | Set pulses for raw status bits 29..0 |
| card_insert | input | 1 | Card inserted pulse |
| card_remove | input | 1 | Card removed pulse |
| dma_set | input | DMA_W | Set pulses for DMA status bits |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume that `card_insert` and `card_remove` are single-cycle pulses driven from registers. They also assume that register writes do not overlap with reset. Under those assumptions the two card flags never read 1 together, and a clear that follows a write holds for every bit that has no event set pending in that cycle. The stimulus drives all inputs one nanosecond after the rising edge. Most of the time it keeps the card pulses exclusive, and it drives both high at once on purpose in only a few cycles, to exercise the ignore rule. It places event sets on the exact cycles of software clears, so that the rule that a set wins is reached often.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int ADDR_W = 8,
  parameter int DMA_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [29:0]       src_set,
  input  logic              card_insert,
  input  logic              card_remove,
  input  logic [DMA_W-1:0]  dma_set,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_MSTS = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CARD = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(8'h14);
  localparam int IEN_BIT = 4;
  localparam int SUM_BIT = 8;
  localparam logic [31:0] CTRL_RST = 32'h0000_0300;
  localparam logic [31:0] SELF_CLR = 32'h0000_0007;

  logic [31:0]      ctrl_q, mask_q, raw_q;
  logic             present_q;
  logic [DMA_W-1:0] dma_q;

  wire ins = card_insert & ~card_remove;
  wire rem = card_remove & ~card_insert;

  wire [31:0] raw_set = {rem, ins, src_set};
  wire [31:0] raw_hwclr = {ins, rem, 30'd0};
  wire [31:0] raw_swclr = (reg_wr && (reg_addr == A_MSTS || reg_addr == A_RAW)) ? reg_wdata : 32'd0;
  wire [31:0] raw_d = (raw_q & ~raw_swclr & ~raw_hwclr) | raw_set;

  wire [DMA_W-1:0] dma_sum = (|dma_set[1:0]) ? DMA_W'(1) << SUM_BIT : '0;
  wire [DMA_W-1:0] dma_swclr = (reg_wr && reg_addr == A_DMA) ? reg_wdata[DMA_W-1:0] : '0;
  wire [DMA_W-1:0] dma_d = (dma_q & ~dma_swclr) | dma_set | dma_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      mask_q    <= '0;
      raw_q     <= '0;
      present_q <= 1'b1;
      dma_q     <= '0;
    end else begin
      raw_q <= raw_d;
      dma_q <= dma_d;
      if (ins) present_q <= 1'b1;
      else if (rem) present_q <= 1'b0;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & ~SELF_CLR;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_MASK:  reg_rdata = mask_q;
      A_MSTS:  reg_rdata = raw_q & mask_q;
      A_RAW:   reg_rdata = raw_q;
      A_CARD:  reg_rdata = {23'd0, present_q, 8'd0};
      A_DMA:   reg_rdata = 32'(dma_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  assign irq = ctrl_q[IEN_BIT] & (|(raw_q & mask_q));

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[IEN_BIT] |-> !irq); // R1
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_RAW) |=> ((raw_q & $past(reg_wdata) & ~$past({card_remove, card_insert, src_set})) == 32'd0)); // R3
  AST_CARD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_q[30] && raw_q[31])); // R4
  AST_CTRL_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> (ctrl_q == ($past(reg_wdata) & ~SELF_CLR))); // R5
  AST_DMA_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_set[1:0]) |=> dma_q[SUM_BIT]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((raw_q[29:0] & $past(src_set)) == $past(src_set))); // R8
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [29:0] src_set = 0;
  logic card_insert = 0, card_remove = 0;
  logic [9:0] dma_set = 0;
  logic irq;

  int total = 0, bad = 0, cyc = 0;
  string req = "R7";

  logic [31:0] m_ctrl, m_mask, m_raw, m_card, m_dma;

  irq_status_unit dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set), .card_insert(card_insert),
    .card_remove(card_remove), .dma_set(dma_set), .irq(irq));

  always #2 clk = ~clk;

  // behavioural reference, updated from the requirement text
  always @(posedge clk) begin
    logic [31:0] setv, clrv, dclr, dset;
    if (!rst_n) begin
      m_ctrl = 32'h300; m_mask = 0; m_raw = 0; m_card = 32'h100; m_dma = 0;
    end else begin
      setv = {2'b00, src_set};
      clrv = 0;
      if (reg_wr && (reg_addr == 8'h08 || reg_addr == 8'h0C)) clrv = reg_wdata;
      if (card_insert && !card_remove) begin setv[30] = 1; clrv[31] = 1; m_card[8] = 1; end
      if (card_remove && !card_insert) begin setv[31] = 1; clrv[30] = 1; m_card[8] = 0; end
      m_raw = (m_raw & ~clrv) | setv;
      dset = {22'd0, dma_set};
      if (dma_set[0] || dma_set[1]) dset[8] = 1;
      dclr = (reg_wr && reg_addr == 8'h14) ? {22'd0, reg_wdata[9:0]} : 0;
      m_dma = (m_dma & ~dclr) | dset;
      if (reg_wr && reg_addr == 8'h00) m_ctrl = reg_wdata & 32'hFFFF_FFF8;
      if (reg_wr && reg_addr == 8'h04) m_mask = reg_wdata;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_mask;
      8'h08: return m_raw & m_mask;
      8'h0C: return m_raw;
      8'h10: return m_card;
      8'h14: return m_dma;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    logic e_irq;
    cyc++;
    if (rst_n) begin
      e_irq = m_ctrl[4] && ((m_raw & m_mask) != 0);
      total++;
      if (irq !== e_irq) begin
        bad++;
        $display("FAIL %s R1 irq cycle %0d: got %b exp %b", req, cyc, irq, e_irq);
      end
      total++;
      if (reg_rdata !== exp_rd(reg_addr)) begin
        bad++;
        $display("FAIL %s read addr %h cycle %0d: got %h exp %h", req, reg_addr, cyc, reg_rdata, exp_rd(reg_addr));
      end
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [29:0] s, input logic ci, input logic cr, input logic [9:0] ds);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = w; reg_wdata = d; src_set = s;
    card_insert = ci; card_remove = cr; dma_set = ds;
  endtask

  task automatic rd(input logic [7:0] a);
    step(a, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    req = "R7";
    for (int a = 0; a < 8; a++) rd(8'(a * 4));
    req = "R10";
    step(8'h04, 1, 32'hFFFF_FFFF, 0, 0, 0, 0); rd(8'h04);
    step(8'h04, 1, 32'h0000_00F0, 0, 0, 0, 0); rd(8'h04);
    req = "R1";
    step(8'h0C, 0, 0, 30'h30, 0, 0, 0); rd(8'h08); rd(8'h0C);
    step(8'h00, 1, 32'h0000_0010, 0, 0, 0, 0); rd(8'h00);
    step(8'h04, 1, 32'h0, 0, 0, 0, 0); rd(8'h08);
    step(8'h04, 1, 32'h20, 0, 0, 0, 0); rd(8'h08);
    req = "R3";
    step(8'h08, 1, 32'h20, 0, 0, 0, 0); rd(8'h0C);
    step(8'h0C, 1, 32'h10, 0, 0, 0, 0); rd(8'h0C);
    req = "R8";
    step(8'h0C, 1, 32'h1, 30'h1, 0, 0, 0); rd(8'h0C);
    step(8'h14, 1, 32'h3FF, 0, 0, 0, 10'h2); rd(8'h14);
    req = "R4";
    step(8'h10, 0, 0, 0, 0, 1, 0); rd(8'h10); rd(8'h0C);
    step(8'h10, 0, 0, 0, 1, 0, 0); rd(8'h10); rd(8'h0C);
    step(8'h10, 0, 0, 0, 1, 1, 0); rd(8'h10); rd(8'h0C);
    step(8'h0C, 1, 32'h4000_0000, 0, 1, 0, 0); rd(8'h0C);
    req = "R5";
    step(8'h00, 1, 32'hFFFF_FFFF, 0, 0, 0, 0); rd(8'h00);
    step(8'h00, 1, 32'h0000_0017, 0, 0, 0, 0); rd(8'h00);
    req = "R6";
    step(8'h14, 0, 0, 0, 0, 0, 10'h1); rd(8'h14);
    step(8'h14, 1, 32'hFFFF_FD00, 0, 0, 0, 0); rd(8'h14);
    step(8'h14, 0, 0, 0, 0, 0, 10'h204); rd(8'h14);
    step(8'h14, 1, 32'hFFFF_FFFF, 0, 0, 0, 0); rd(8'h14);
    req = "R9";
    step(8'h0C, 0, 0, 30'h3FF, 0, 0, 0);
    step(8'h18, 1, 32'hFFFF_FFFF, 0, 0, 0, 0); rd(8'h18); rd(8'h0C); rd(8'h04);
    step(8'h10, 1, 32'hFFFF_FFFF, 0, 0, 0, 0); rd(8'h10); rd(8'h04);
    step(8'hFC, 1, 32'h0, 0, 0, 0, 0); rd(8'hFC); rd(8'h00);
    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [1:0] c;
      a = 8'(($urandom % 8) * 4);
      c = 2'($urandom % 16 == 0 ? $urandom : 0);
      step(a, ($urandom % 3) == 0, $urandom, 30'($urandom & $urandom),
           c[0], c[1], 10'($urandom & $urandom & $urandom));
    end
    rd(8'h0C);
    rd(8'h0C);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule